// File: doc/BRIEF.md
# Five-Level Hybrid Phase Gate Generator

This block turns a running fundamental angle and a modulation index into the six gate commands for one phase of a five-level hybrid inverter. The phase stacks a two-level leg (switches S1/S2, contributing plus or minus half the bus) under a full H-bridge fed from a half-voltage source (Sa1/Sa2 on one bridge leg, Sa3/Sa4 on the other). Together they reach five output levels. The leg runs as a square wave at the fundamental. The bridge is modulated within angle segments, so the sum steps between two adjacent levels inside each segment.

Internally, three control bits are formed once per carrier period: the leg polarity, a window flag that marks the central segment of each half cycle, and a PWM bit whose on-time is computed from a folded-sine lookup. A small combinational map turns those bits into the switch commands. It also picks the redundant zero state of the bridge so that each PWM edge moves only one bridge leg. A three-phase drive uses three instances whose angle inputs differ by a third of a turn.

Top module: `hyb5_gate_gen`

## Requirements
- R1: One clock edge after reset is released, and from then on, s1_o is 1 while angle_i is in the first half turn (angle MSB 0) and 0 otherwise. s2_o is always the complement of s1_o.
- R2: After that first edge, sa2_o is the complement of sa1_o and sa4_o is the complement of sa3_o. The two switches of a bridge leg are never on together.
- R3: Let pos be angle_i without its MSB, and H half a turn in angle counts. The central window is 6*pos >= H and 6*pos < 5*H. Level, in units of half the leg bus, is +1/-1 from S1/S2, plus +1 for Sa1&Sa4, -1 for Sa2&Sa3, and 0 otherwise. Under a steady angle the level may take only these values:
  - first half, outside the window: 0 and +1;
  - first half, inside the window: +1 and +2;
  - second half, outside the window: 0 and -1;
  - second half, inside the window: -1 and -2.
- R4: Outside the window, the number of cycles per carrier period spent at level 0 is CAR_CYC*(1 - 2*m*|sin|), clamped at 0. Here m = ma_i/2^MA_W. With ma_i = 0 the level is 0 for the whole period.
- R5: Inside the window, the number of cycles per carrier period spent at level ±2 is CAR_CYC*(2*m*|sin| - 1), clamped at 0. With ma_i = 0 level ±2 never occurs.
- R6: angle_i and ma_i are sampled once per carrier period: on the first clock edge after reset, then every CAR_CYC edges. s1_o and sa1_o change only on those edges.
- R7: When the bridge must toggle between +1/2 and 0 (first-half window, second half outside the window), sa1_o stays 1. When it must toggle between -1/2 and 0, sa1_o stays 0. Only sa3_o/sa4_o follow the PWM.
- R8: While rst_ni is low, all six gate outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| angle_i | input | ANG_W | Fundamental angle, one full turn = 2^ANG_W |
| ma_i | input | MA_W | Modulation index, unsigned fraction of 2^MA_W |
| s1_o | output | 1 | Leg upper switch |
| s2_o | output | 1 | Leg lower switch |
| sa1_o | output | 1 | Bridge leg A upper |
| sa2_o | output | 1 | Bridge leg A lower |
| sa3_o | output | 1 | Bridge leg B upper |
| sa4_o | output | 1 | Bridge leg B lower |

## Verification
The bench builds the block with a 100-cycle carrier period and otherwise default widths (12-bit angle, 8-bit index, 64-entry quarter-sine table). With that period a full carrier window is short enough to measure duty directly many times over. Steady angles in all four segment types, the clamp at zero just inside the window, and the full-period extreme at zero index are all observed within a few hundred cycles each. The short period also lets the bench count edges from reset and hit the exact sampling edge, so a mid-period angle change can be shown to wait for the next boundary.

// File: rtl/hyb5_pkg.sv
package hyb5_pkg;
  typedef struct packed {
    logic s1;
    logic s2;
    logic sa1;
    logic sa2;
    logic sa3;
    logic sa4;
  } gate_t;
endpackage

// File: rtl/hyb5_sine_rom.sv
module hyb5_sine_rom #(
  parameter int IDX_W = 6,
  parameter int SIN_W = 10
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [SIN_W-1:0] sin_o
);
  localparam int N    = 1 << IDX_W;
  localparam int HALF = 4 * N;          // half turn in half-step units
  localparam longint FS = (longint'(1) << SIN_W) - 1;

  // rational sine approximation at the centre of each quarter-wave bin
  function automatic longint sin_pt(input int i);
    longint x, p, num, den;
    x   = 2 * i + 1;
    p   = x * (HALF - x);
    num = 16 * p * FS;
    den = 5 * longint'(HALF) * HALF - 4 * p;
    return (num + den / 2) / den;
  endfunction

  logic [SIN_W-1:0] tbl [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_tbl
    assign tbl[gi] = SIN_W'(sin_pt(gi));
  end

  assign sin_o = tbl[idx_i];
endmodule

// File: rtl/hyb5_seg_decode.sv
module hyb5_seg_decode #(
  parameter int ANG_W = 12,
  parameter int IDX_W = 6
) (
  input  logic [ANG_W-1:0] angle_i,
  output logic             leg_pos_o,
  output logic             window_o,
  output logic [IDX_W-1:0] sin_idx_o
);
  localparam int PW   = ANG_W - 1;
  localparam int QW   = ANG_W - 2;
  localparam int HALF = 1 << PW;
  localparam logic [PW-1:0] WIN_LO = PW'((HALF + 5) / 6);
  localparam logic [PW-1:0] WIN_HI = PW'((5 * HALF + 5) / 6);

  logic [PW-1:0] pos;
  logic [QW-1:0] q;

  assign pos       = angle_i[PW-1:0];
  assign leg_pos_o = ~angle_i[ANG_W-1];
  assign window_o  = (pos >= WIN_LO) && (pos < WIN_HI);
  // fold second quarter onto the first
  assign q         = pos[PW-1] ? ~pos[QW-1:0] : pos[QW-1:0];
  assign sin_idx_o = q[QW-1 -: IDX_W];
endmodule

// File: rtl/hyb5_width_calc.sv
module hyb5_width_calc #(
  parameter int MA_W    = 8,
  parameter int SIN_W   = 10,
  parameter int CAR_CYC = 20000,
  parameter int CW      = 15
) (
  input  logic [SIN_W-1:0] sin_i,
  input  logic [MA_W-1:0]  ma_i,
  input  logic             window_i,
  output logic [CW-1:0]    width_o
);
  localparam int FB = MA_W + SIN_W;
  localparam int WW = FB + CW + 1;
  localparam logic [FB:0] ONE = (FB+1)'(1) << FB;

  logic [FB-1:0] prod;
  logic [FB:0]   twice;
  logic [FB:0]   ctrl;
  logic [WW-1:0] wide;

  assign prod  = FB'(ma_i) * FB'(sin_i);
  assign twice = {prod, 1'b0};

  always_comb begin
    if (window_i) ctrl = (twice > ONE) ? twice - ONE : '0;
    else          ctrl = (twice < ONE) ? ONE - twice : '0;
  end

  assign wide    = WW'(ctrl) * WW'(CAR_CYC);
  assign width_o = wide[FB +: CW];
endmodule

// File: rtl/hyb5_switch_map.sv
module hyb5_switch_map
  import hyb5_pkg::*;
(
  input  logic  leg_pos_i,
  input  logic  window_i,
  input  logic  pwm_i,
  output gate_t gates_o
);
  logic up_ctx;   // bridge toggles between +half and zero

  assign up_ctx      = ~(leg_pos_i ^ window_i);
  assign gates_o.s1  = leg_pos_i;
  assign gates_o.s2  = ~leg_pos_i;
  assign gates_o.sa1 = up_ctx;
  assign gates_o.sa2 = ~up_ctx;
  assign gates_o.sa3 = up_ctx ^ pwm_i;
  assign gates_o.sa4 = ~(up_ctx ^ pwm_i);
endmodule

// File: rtl/hyb5_gate_gen.sv
module hyb5_gate_gen
  import hyb5_pkg::*;
#(
  parameter int ANG_W   = 12,
  parameter int MA_W    = 8,
  parameter int CAR_CYC = 20000,
  parameter int IDX_W   = 6,
  parameter int SIN_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ANG_W-1:0] angle_i,
  input  logic [MA_W-1:0]  ma_i,
  output logic             s1_o,
  output logic             s2_o,
  output logic             sa1_o,
  output logic             sa2_o,
  output logic             sa3_o,
  output logic             sa4_o
);
  localparam int CW = $clog2(CAR_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CAR_CYC - 1);

  logic [CW-1:0]    cnt_q, cnt_d, width_q, width_d, width_new;
  logic             pos_q, pos_d, win_q, win_d, pos_new, win_new, pwm_d;
  logic             load;
  logic [IDX_W-1:0] sin_idx;
  logic [SIN_W-1:0] sin_val;
  gate_t            gates_d, gates_q;

  hyb5_seg_decode #(.ANG_W(ANG_W), .IDX_W(IDX_W)) u_seg (
    .angle_i  (angle_i),
    .leg_pos_o(pos_new),
    .window_o (win_new),
    .sin_idx_o(sin_idx)
  );

  hyb5_sine_rom #(.IDX_W(IDX_W), .SIN_W(SIN_W)) u_rom (
    .idx_i(sin_idx),
    .sin_o(sin_val)
  );

  hyb5_width_calc #(.MA_W(MA_W), .SIN_W(SIN_W), .CAR_CYC(CAR_CYC), .CW(CW)) u_wid (
    .sin_i   (sin_val),
    .ma_i    (ma_i),
    .window_i(win_new),
    .width_o (width_new)
  );

  assign load    = (cnt_q == LAST);
  assign cnt_d   = load ? '0 : cnt_q + 1'b1;
  assign pos_d   = load ? pos_new   : pos_q;
  assign win_d   = load ? win_new   : win_q;
  assign width_d = load ? width_new : width_q;
  assign pwm_d   = (cnt_d < width_d);

  hyb5_switch_map u_map (
    .leg_pos_i(pos_d),
    .window_i (win_d),
    .pwm_i    (pwm_d),
    .gates_o  (gates_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= LAST;   // first edge after reset samples the inputs
      pos_q   <= 1'b0;
      win_q   <= 1'b0;
      width_q <= '0;
      gates_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      pos_q   <= pos_d;
      win_q   <= win_d;
      width_q <= width_d;
      gates_q <= gates_d;
    end
  end

  assign s1_o  = gates_q.s1;
  assign s2_o  = gates_q.s2;
  assign sa1_o = gates_q.sa1;
  assign sa2_o = gates_q.sa2;
  assign sa3_o = gates_q.sa3;
  assign sa4_o = gates_q.sa4;
endmodule

// File: rtl/hyb5_gate_chk.sv
module hyb5_gate_chk #(
  parameter int CAR_CYC = 20000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic s1_o,
  input logic s2_o,
  input logic sa1_o,
  input logic sa2_o,
  input logic sa3_o,
  input logic sa4_o
);
  localparam int CW = $clog2(CAR_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CAR_CYC - 1);

  logic          seen_q;
  logic [CW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      ph_q   <= LAST;
    end else begin
      seen_q <= 1'b1;
      ph_q   <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
  end

  // R1
  leg_compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (s1_o != s2_o));

  // R2
  brg_a_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sa1_o && sa2_o));

  // R2
  brg_b_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sa3_o && sa4_o));

  // R6
  leg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != '0) |-> $stable(s1_o));

  // R6
  ctx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != '0) |-> $stable(sa1_o));

  // R8
  always_comb begin
    if (!rst_ni) begin
      rst_quiet_chk: assert ({s1_o, s2_o, sa1_o, sa2_o, sa3_o, sa4_o} == 6'b0);
    end
  end
endmodule

bind hyb5_gate_gen hyb5_gate_chk #(.CAR_CYC(CAR_CYC)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .s1_o  (s1_o),
  .s2_o  (s2_o),
  .sa1_o (sa1_o),
  .sa2_o (sa2_o),
  .sa3_o (sa3_o),
  .sa4_o (sa4_o)
);

// File: tb/hyb5_gate_gen_tb.sv
module hyb5_gate_gen_tb;
  localparam int CAR   = 100;
  localparam int ANG_W = 12;
  localparam int MA_W  = 8;
  localparam int HALF  = 1 << (ANG_W - 1);
  localparam int TOL   = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [ANG_W-1:0] angle_i = '0;
  logic [MA_W-1:0]  ma_i = '0;
  logic s1_o, s2_o, sa1_o, sa2_o, sa3_o, sa4_o;

  int checks = 0;
  int fails  = 0;
  int ecnt   = 0;
  bit done   = 1'b0;

  hyb5_gate_gen #(.ANG_W(ANG_W), .MA_W(MA_W), .CAR_CYC(CAR)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .angle_i(angle_i), .ma_i(ma_i),
    .s1_o(s1_o), .s2_o(s2_o), .sa1_o(sa1_o), .sa2_o(sa2_o),
    .sa3_o(sa3_o), .sa4_o(sa4_o)
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (!rst_ni) ecnt <= 0;
    else         ecnt <= ecnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int level();
    int leg, br;
    leg = s1_o ? 1 : -1;
    br  = (sa1_o && sa4_o) ? 1 : ((sa2_o && sa3_o) ? -1 : 0);
    return leg + br;
  endfunction

  function automatic bit in_window(input int ang);
    int pos;
    pos = ang % HALF;
    return (6 * pos >= HALF) && (6 * pos < 5 * HALF);
  endfunction

  function automatic int exp_width(input int ang, input int ma);
    real th, s, m, c;
    th = real'(ang) * 2.0 * 3.14159265358979 / real'(1 << ANG_W);
    s  = $sin(th);
    if (s < 0.0) s = -s;
    m  = real'(ma) / real'(1 << MA_W);
    c  = in_window(ang) ? (2.0 * m * s - 1.0) : (1.0 - 2.0 * m * s);
    if (c < 0.0) c = 0.0;
    if (c > 1.0) c = 1.0;
    return int'(c * real'(CAR));
  endfunction

  // steady angle: measure one carrier period of levels
  task automatic run_case(input int ang, input int ma, input bit exact);
    bit pos_half, win, ctx;
    int act_lvl, base_lvl, n_act, n_bad, n_ctx, n_cmp, ew;
    string wreq;
    angle_i = ANG_W'(ang);
    ma_i    = MA_W'(ma);
    repeat (2 * CAR + 2) @(negedge clk_i);
    pos_half = (ang < HALF);
    win      = in_window(ang);
    ctx      = (pos_half == win);
    base_lvl = pos_half ? 1 : -1;
    act_lvl  = win ? 2 * base_lvl : 0;
    n_act = 0; n_bad = 0; n_ctx = 0; n_cmp = 0;
    for (int i = 0; i < CAR; i++) begin
      if (level() == act_lvl) n_act++;
      else if (level() != base_lvl) n_bad++;
      if (sa1_o != ctx) n_ctx++;
      if ((s1_o == s2_o) || (sa1_o == sa2_o) || (sa3_o == sa4_o)) n_cmp++;
      @(negedge clk_i);
    end
    ew   = exp_width(ang, ma);
    wreq = win ? "R5 window width" : "R4 outer width";
    if (exact) check(n_act == ew, wreq, n_act, ew);
    else check((n_act - ew <= TOL) && (ew - n_act <= TOL), wreq, n_act, ew);
    check(n_bad == 0, "R3 level pair", n_bad, 0);
    check(n_ctx == 0, "R7 zero state leg", n_ctx, 0);
    check(n_cmp == 0, "R2 complements", n_cmp, 0);
    check(s1_o == pos_half, "R1 leg polarity", int'(s1_o), int'(pos_half));
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk_i);
    // R8
    check({s1_o, s2_o, sa1_o, sa2_o, sa3_o, sa4_o} == 6'b0, "R8 reset gates",
          int'({s1_o, s2_o, sa1_o, sa2_o, sa3_o, sa4_o}), 0);
    angle_i = ANG_W'(1024);
    ma_i    = MA_W'(205);
    rst_ni  = 1'b1;
    @(negedge clk_i);
    // R1: first edge samples the angle
    check(s1_o == 1'b1 && s2_o == 1'b0, "R1 first edge", int'({s1_o, s2_o}), 2);
  endtask

  task automatic test_hold();
    int bad;
    angle_i = ANG_W'(114);
    do @(negedge clk_i); while (((ecnt - 1) % CAR) != 0);
    do @(negedge clk_i); while (((ecnt - 1) % CAR) != 0);
    angle_i = ANG_W'(2162);
    bad = 0;
    repeat (CAR - 1) begin
      @(negedge clk_i);
      if (s1_o != 1'b1) bad++;
    end
    // R6
    check(bad == 0, "R6 hold until boundary", bad, 0);
    @(negedge clk_i);
    check(s1_o == 1'b0, "R6 update at boundary", int'(s1_o), 0);
  endtask

  initial begin
    test_reset();
    run_case(114,  205, 1'b0);  // 10 deg, outer
    run_case(330,  205, 1'b0);  // 29 deg, outer
    run_case(353,  205, 1'b1);  // 31 deg, window, clamps to 0
    run_case(512,  205, 1'b0);  // 45 deg
    run_case(1024, 205, 1'b0);  // 90 deg
    run_case(1024, 255, 1'b0);  // near full index
    run_case(2162, 205, 1'b0);  // 190 deg
    run_case(3072, 205, 1'b0);  // 270 deg
    run_case(3413, 205, 1'b0);  // 300 deg
    run_case(3982, 205, 1'b0);  // 350 deg
    run_case(114,  0,   1'b1);  // R4 full period at zero
    run_case(1024, 0,   1'b1);  // R5 never at peak level
    test_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule